// File: doc/BRIEF.md
# Parked-Port Test Clock Gate

This block sits in a test-access bridge that fans one primary test clock out to several local scan ports. For each port it produces a gated copy of the primary clock. Whether that copy runs depends on the port's park condition and on one hold control bit. A port that is active, meaning not parked, always gets a running clock. A port parked in an idle or pause state gets a running clock unless the hold bit asks for parked clocks to be stopped. A port parked in the reset state gets a fixed burst of pulses and is then stopped, whatever the hold bit says.

Each port has its own saturating pulse counter. The counter restarts every time the port enters the reset park state. A single status output reports that some port parked in reset has received its whole burst.

The gating uses a latch that is transparent while the clock is low. An enable change therefore cannot shorten or split a high phase. A stopped output is held at logic 0.

Top module: `tck_park_gate`

## Requirements
- R1: A port whose park code is 2'b00 (active) gets a gated-clock pulse on every primary-clock high phase, whether the hold bit is 0 or 1.
- R2: A port whose park code is 2'b01 (parked idle) or 2'b10 (parked pause) gets a gated-clock pulse on every high phase while the hold bit is 0.
- R3: A port whose park code is 2'b01 or 2'b10 has its gated clock held at 0 while the hold bit is 1.
- R4: Park code 2'b11 (parked reset) is sampled on a rising edge. The port then gets gated pulses on exactly the next PULSE_LIMIT rising edges (512 by default), and its gated clock stays at 0 afterwards.
- R5: The status output is 1 exactly when at least one port is in the parked-reset code and has received its full PULSE_LIMIT pulses. In every other case it is 0, including after the port leaves the parked-reset code.
- R6: Each new entry into the parked-reset code restarts that port's count, so a second entry again yields exactly PULSE_LIMIT pulses.
- R7: While a port holds the parked-reset code, the hold bit has no effect on its pulse count.
- R8: A gated clock output is never high while the primary clock is low.
- R9: Reset is synchronous and active low. While it is applied, every port is treated as active (running clock) whatever its park code, and the status output is 0.
- R10: Ports are independent. Port i takes its park code from bits [2i+1:2i] of the park input and drives bit i of the gated-clock output. One port's code or count never alters another port's clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck_i | input | 1 | Primary test clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| park_i | input | 2*NPORT | Park code per port: 00 active, 01 idle, 10 pause, 11 reset |
| hold_parked_i | input | 1 | Hold bit: 1 stops the clocks of ports parked in idle or pause |
| gclk_o | output | NPORT | Gated test clock, one per port |
| burst_done_o | output | 1 | Some port parked in reset has received its full burst |

## Verification
The gating is tried with every park code under both values of the hold bit. Pulses are counted over a window, and the gated outputs are also checked during low phases. This separates a missing pulse from a stuck or glitching output. The reset burst is entered from a stopped parked-idle state, so that every pulse in the window belongs to the burst. The pulses on the last allowed edge and on the first forbidden edge are checked on their own, with the status output read around the cutoff. A second entry with the hold bit cleared shows that the count restarts and that the hold bit is ignored. Meanwhile the neighbouring ports are kept in other codes to expose any cross-coupling.

// File: rtl/tpg_pkg.sv
// Shared types for the parked-port test clock gate.
package tpg_pkg;
    // Per-port park code as driven on the park input.
    typedef enum logic [1:0] {
        PK_ACTIVE = 2'b00,
        PK_IDLE   = 2'b01,
        PK_PAUSE  = 2'b10,
        PK_RESET  = 2'b11
    } park_e;
endpackage

// File: rtl/tpg_clk_gate.sv
// Glitch-free clock gate: the enable passes through a latch that is
// transparent only while the clock is low. The output is the clock ANDed
// with the latched enable.
// Assumes the enable settles before the rising edge of clk_i.
module tpg_clk_gate (
    input  logic clk_i,
    input  logic en_i,
    output logic en_latched_o,
    output logic gclk_o
);
    logic en_lat;

    // Capture the enable during the low phase only.
    always_latch begin
        if (!clk_i) en_lat = en_i;
    end

    // Gated clock and the latched enable for observers.
    assign gclk_o       = clk_i & en_lat;
    assign en_latched_o = en_lat;
endmodule

// File: rtl/tpg_port_slice.sv
// One local port: registers the park code, counts the reset burst and
// derives the gate enable.
// Assumes park_i and hold_parked_i are stable around rising edges of clk_i.
module tpg_port_slice #(
    parameter int PULSE_LIMIT = 512,
    parameter int CNT_W       = $clog2(PULSE_LIMIT + 1)
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [1:0] park_i,
    input  logic       hold_parked_i,
    output logic       gclk_o,
    output logic       done_o,
    output logic       in_reset_park_o
);
    import tpg_pkg::*;

    localparam logic [CNT_W-1:0] LIMIT_C = CNT_W'(PULSE_LIMIT);

    park_e            state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             full;
    logic             en;
    logic             en_latched;

    // Register the park code; reset treats the port as active.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= PK_ACTIVE;
        else         state_q <= park_e'(park_i);
    end

    // Count pulses while parked in reset. Clear outside it and saturate at the limit.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)                 cnt_q <= '0;
        else if (state_q != PK_RESET) cnt_q <= '0;
        else if (!full)              cnt_q <= cnt_q + 1'b1;
    end

    assign full = (cnt_q == LIMIT_C);

    // Gate enable policy per park code.
    always_comb begin
        unique case (state_q)
            PK_ACTIVE:         en = 1'b1;
            PK_IDLE, PK_PAUSE: en = !hold_parked_i;
            PK_RESET:          en = !full;
            default:           en = 1'b1;
        endcase
    end

    tpg_clk_gate u_gate (
        .clk_i        (clk_i),
        .en_i         (en),
        .en_latched_o (en_latched),
        .gclk_o       (gclk_o)
    );

    assign in_reset_park_o = (state_q == PK_RESET);
    assign done_o          = in_reset_park_o && full;

    // R1: an active port keeps its gate open.
    p_active_runs_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == PK_ACTIVE) |-> en_latched);
    // R2: an idle or pause parked port runs when the hold bit is 0.
    p_parked_runs_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((state_q == PK_IDLE || state_q == PK_PAUSE) && !hold_parked_i) |-> en_latched);
    // R3: an idle or pause parked port is stopped when the hold bit is 1.
    p_parked_holds_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((state_q == PK_IDLE || state_q == PK_PAUSE) && hold_parked_i) |-> !en_latched);
    // R4: the burst ends once the count reaches the limit.
    p_limit_stops_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == PK_RESET && cnt_q == LIMIT_C) |-> !en_latched);
    // R4: the counter never passes the limit.
    p_no_overflow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= LIMIT_C);
    // R6: entering the reset park state starts from zero.
    p_entry_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == PK_RESET && $past(state_q) != PK_RESET) |-> (cnt_q == '0));
endmodule

// File: rtl/tck_park_gate.sv
// Parked-port test clock gate: one gated test clock per local port, plus a
// status output that reports a finished reset burst on any port.
// Assumes all inputs are synchronous to tck_i.
module tck_park_gate #(
    parameter int NPORT       = 3,
    parameter int PULSE_LIMIT = 512
) (
    input  logic               tck_i,
    input  logic               rst_ni,
    input  logic [2*NPORT-1:0] park_i,
    input  logic               hold_parked_i,
    output logic [NPORT-1:0]   gclk_o,
    output logic               burst_done_o
);
    localparam int CNT_W = $clog2(PULSE_LIMIT + 1);

    logic [NPORT-1:0] done_vec;
    logic [NPORT-1:0] reset_park_vec;

    // One slice per local port.
    for (genvar i = 0; i < NPORT; i++) begin : g_port
        tpg_port_slice #(
            .PULSE_LIMIT (PULSE_LIMIT),
            .CNT_W       (CNT_W)
        ) u_slice (
            .clk_i           (tck_i),
            .rst_ni          (rst_ni),
            .park_i          (park_i[2*i+1 -: 2]),
            .hold_parked_i   (hold_parked_i),
            .gclk_o          (gclk_o[i]),
            .done_o          (done_vec[i]),
            .in_reset_park_o (reset_park_vec[i])
        );
    end

    // Status is the OR of the finished bursts.
    assign burst_done_o = |done_vec;

    // R5: status is only raised while some port is parked in reset.
    p_status_needs_reset_r5: assert property (@(posedge tck_i) disable iff (!rst_ni)
        burst_done_o |-> (|reset_park_vec));
    // R9: status is low while reset is applied.
    p_status_reset_r9: assert property (@(posedge tck_i)
        !rst_ni |=> !burst_done_o);
endmodule

// File: tb/tck_park_gate_test.sv
module tck_park_gate_test;
    localparam int NPORT = 3;
    localparam int LIMIT = 512;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [2*NPORT-1:0] park = '1;
    logic               hold = 1'b1;
    logic [NPORT-1:0]   gclk;
    logic               done;

    int checks = 0;
    int errors = 0;

    tck_park_gate #(.NPORT(NPORT), .PULSE_LIMIT(LIMIT)) uut (
        .tck_i         (clk),
        .rst_ni        (rst_n),
        .park_i        (park),
        .hold_parked_i (hold),
        .gclk_o        (gclk),
        .burst_done_o  (done)
    );

    always #4 clk = ~clk;   // 125 MHz

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Wait for a rising edge; return the high-phase and low-phase samples.
    task automatic step(output logic [NPORT-1:0] hi, output logic [NPORT-1:0] lo,
                        output logic st);
        @(posedge clk);
        #2;
        hi = gclk;
        st = done;
        #4;
        lo = gclk;
    endtask

    // Count pulses over n edges, starting with the next edge, and check the low phases.
    task automatic count(input int n, output int cnt [NPORT], output int low_bad);
        logic [NPORT-1:0] hi, lo;
        logic st;
        for (int p = 0; p < NPORT; p++) cnt[p] = 0;
        low_bad = 0;
        for (int k = 0; k < n; k++) begin
            step(hi, lo, st);
            for (int p = 0; p < NPORT; p++) if (hi[p]) cnt[p]++;
            if (lo != '0) low_bad++;
        end
    endtask

    task automatic t_reset();
        logic [NPORT-1:0] hi, lo;
        logic st;
        for (int k = 0; k < 3; k++) step(hi, lo, st);
        check(hi == '1, "R9 clocks run in reset", int'(hi), (1 << NPORT) - 1);
        check(st == 1'b0, "R9 status low in reset", int'(st), 0);
        park  = '0;
        hold  = 1'b0;
        rst_n = 1'b1;
    endtask

    // All ports in one code and one hold value; 20 edges after one settling edge.
    task automatic t_uniform(input logic [1:0] code, input logic h, input string req,
                             input bit expect_run);
        int cnt [NPORT];
        int lb;
        logic [NPORT-1:0] hi, lo;
        logic st;
        park = {NPORT{code}};
        hold = h;
        step(hi, lo, st);
        count(20, cnt, lb);
        for (int p = 0; p < NPORT; p++)
            check(cnt[p] == (expect_run ? 20 : 0), req, cnt[p], expect_run ? 20 : 0);
        check(lb == 0, "R8 low phase quiet", lb, 0);
    endtask

    // Port0 enters parked reset from a stopped idle state. Port1 is active, port2 idle.
    // When clear_hold_after is set, the hold bit is cleared after the entry edge.
    task automatic t_burst(input string req, input bit clear_hold_after);
        logic [NPORT-1:0] hi, lo;
        logic st;
        int n0, n1, lb;
        n0 = 0; n1 = 0; lb = 0;
        park = {2'b01, 2'b00, 2'b01};
        hold = 1'b1;
        step(hi, lo, st);
        step(hi, lo, st);
        park = {2'b01, 2'b00, 2'b11};
        for (int k = 0; k < 600; k++) begin
            step(hi, lo, st);
            if (k == 0 && clear_hold_after) hold = 1'b0;
            if (hi[0]) n0++;
            if (hi[1]) n1++;
            if (lo != '0) lb++;
            if (k == LIMIT - 1) check(st == 1'b0, "R5 status low before cutoff", int'(st), 0);
            if (k == LIMIT) begin
                check(hi[0] == 1'b1, {req, " last pulse"}, int'(hi[0]), 1);
                check(st == 1'b1, "R5 status high at cutoff", int'(st), 1);
            end
            if (k == LIMIT + 1) check(hi[0] == 1'b0, {req, " stopped after limit"}, int'(hi[0]), 0);
        end
        check(n0 == LIMIT, {req, " burst length"}, n0, LIMIT);
        check(n1 == 600, "R10 neighbour unaffected", n1, 600);
        check(lb == 0, "R8 low phase quiet in burst", lb, 0);
        // Leave reset park: status must drop.
        park = {2'b01, 2'b00, 2'b01};
        hold = 1'b1;
        step(hi, lo, st);
        step(hi, lo, st);
        check(st == 1'b0, "R5 status low after leaving", int'(st), 0);
        check(hi[0] == 1'b0, "R3 port held after leaving", int'(hi[0]), 0);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_uniform(2'b00, 1'b0, "R1 active hold0", 1'b1);
        t_uniform(2'b00, 1'b1, "R1 active hold1", 1'b1);
        t_uniform(2'b01, 1'b0, "R2 idle hold0", 1'b1);
        t_uniform(2'b10, 1'b0, "R2 pause hold0", 1'b1);
        t_uniform(2'b01, 1'b1, "R3 idle hold1", 1'b0);
        t_uniform(2'b10, 1'b1, "R3 pause hold1", 1'b0);
        t_burst("R4", 1'b0);
        t_burst("R6 R7 reentry hold0", 1'b1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule